// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit forms the operand address for indexed addressing within a 2^AW byte space (64 KB at the default width). A request names one of four base registers and one offset source. The offset is either a signed constant of 5, 9 or full width, or an accumulator value. The unit adds the base and the offset, and the sum wraps modulo 2^AW.

In the plain form the sum is the result, one cycle after the request. In the indirect form the sum is a pointer address. The unit reads two bytes there through a byte-wide read handshake, high byte first, and returns the assembled big-endian word as the final address. Postbyte decoding, auto-increment and auto-decrement forms, and the operand access itself belong to neighbouring logic.

Top module: `idx_ea_gen`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd` are low and `ea` is zero.
- R2: `req_base` selects the base register: 0 selects `reg_x`, 1 selects `reg_y`, 2 selects `reg_sp` and 3 selects `reg_pc`.
- R3: Offset kind 0 takes `req_const[4:0]` as a signed value (-16 to +15), sign-extended before the add.
- R4: Offset kind 1 takes `req_const[8:0]` as a signed value (-256 to +255), sign-extended before the add.
- R5: Offset kind 2 takes all of `req_const`. Every sum wraps modulo 2^AW.
- R6: Offset kinds 3 and 4 take `acc_a` and `acc_b` zero-extended. Kind 5 takes the double accumulator `{acc_a, acc_b}`, with `acc_a` as the high half.
- R7: Offset kinds 6 and 7 are reserved and add zero to the base.
- R8: A non-indirect request accepted at a clock edge raises `done` for one cycle after that edge, with `ea` equal to the sum. `ea` then holds until the next `done`.
- R9: An indirect request reads the byte at the sum (the high byte), then the byte at sum+1 (wrapping). `done` rises in the cycle after the second accepted read, with `ea` = {first byte, second byte}.
- R10: While `mem_rd` is high and `mem_ready` is low, `mem_rd` stays high and `mem_addr` stays unchanged.
- R11: A request is accepted only while `busy` is low. Requests presented while busy produce no `done` and do not alter the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_base | input | 2 | Base register select |
| req_ofs_kind | input | 3 | Offset source select |
| req_indirect | input | 1 | Fetch pointer at the sum |
| req_const | input | AW | Constant offset field |
| reg_x | input | AW | Index register X |
| reg_y | input | AW | Index register Y |
| reg_sp | input | AW | Stack pointer |
| reg_pc | input | AW | Program counter |
| acc_a | input | AW/2 | Accumulator A |
| acc_b | input | AW/2 | Accumulator B |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result strobe |
| ea | output | AW | Final effective address |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | AW | Byte read address |
| mem_ready | input | 1 | Read data valid, read accepted |
| mem_rdata | input | AW/2 | Read data byte |

## Verification
The bench builds the unit with the default AW of 16, so bytes are 8 bits and the space is exactly 64 KB. At that width a program counter near 0xFFFF reaches both wrap cases: a 9-bit offset carrying past the top of the space, and a pointer whose high byte sits at 0xFFFF and whose low byte therefore comes from 0x0000. The 16-bit double accumulator offset sets the top bit of the sum. Its memory model inserts zero to three wait states, and it presents requests while a fetch is in flight.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
    typedef enum logic [1:0] {
        BASE_X  = 2'd0,
        BASE_Y  = 2'd1,
        BASE_SP = 2'd2,
        BASE_PC = 2'd3
    } base_sel_e;

    typedef enum logic [2:0] {
        OFS_C5   = 3'd0,
        OFS_C9   = 3'd1,
        OFS_CFUL = 3'd2,
        OFS_ACCA = 3'd3,
        OFS_ACCB = 3'd4,
        OFS_ACCD = 3'd5
    } ofs_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/idx_ofs_ext.sv
module idx_ofs_ext
    import idx_ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [2:0]      sel,
    input  logic [AW-1:0]   cval,
    input  logic [AW/2-1:0] acc_a,
    input  logic [AW/2-1:0] acc_b,
    output logic [AW-1:0]   ofs
);
    localparam int HW = AW / 2;

    always_comb begin
        case (sel)
            3'(OFS_C5):   ofs = {{(AW-5){cval[4]}}, cval[4:0]};
            3'(OFS_C9):   ofs = {{(AW-9){cval[8]}}, cval[8:0]};
            3'(OFS_CFUL): ofs = cval;
            3'(OFS_ACCA): ofs = {{HW{1'b0}}, acc_a};
            3'(OFS_ACCB): ofs = {{HW{1'b0}}, acc_b};
            3'(OFS_ACCD): ofs = {acc_a, acc_b};
            default:      ofs = '0;
        endcase
    end
endmodule

// File: rtl/idx_base_add.sv
module idx_base_add #(
    parameter int AW = 16,
    parameter int NB = 4
) (
    input  logic [$clog2(NB)-1:0] sel,
    input  logic [NB*AW-1:0]      bases,
    input  logic [AW-1:0]         ofs,
    output logic [AW-1:0]         sum
);
    logic [AW-1:0] bank [NB];

    for (genvar i = 0; i < NB; i++) begin : g_bank
        assign bank[i] = bases[i*AW +: AW];
    end

    assign sum = bank[sel] + ofs;
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_base,
    input  logic [2:0]      req_ofs_kind,
    input  logic            req_indirect,
    input  logic [AW-1:0]   req_const,
    input  logic [AW-1:0]   reg_x,
    input  logic [AW-1:0]   reg_y,
    input  logic [AW-1:0]   reg_sp,
    input  logic [AW-1:0]   reg_pc,
    input  logic [AW/2-1:0] acc_a,
    input  logic [AW/2-1:0] acc_b,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   ea,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ready,
    input  logic [AW/2-1:0] mem_rdata
);
    localparam int HW = AW / 2;
    localparam int NB = 4;

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] ptr;
        logic [HW-1:0] hi;
        logic [AW-1:0] ea;
        logic          done;
    } state_t;

    state_t        s_q, s_d;
    logic [AW-1:0] ofs;
    logic [AW-1:0] sum;

    idx_ofs_ext #(.AW(AW)) u_ofs (
        .sel   (req_ofs_kind),
        .cval  (req_const),
        .acc_a (acc_a),
        .acc_b (acc_b),
        .ofs   (ofs)
    );

    idx_base_add #(.AW(AW), .NB(NB)) u_add (
        .sel   (req_base),
        .bases ({reg_pc, reg_sp, reg_y, reg_x}),
        .ofs   (ofs),
        .sum   (sum)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_indirect) begin
                        s_d.st  = ST_HI;
                        s_d.ptr = sum;
                    end else begin
                        s_d.ea   = sum;
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_HI: begin
                if (mem_ready) begin
                    s_d.hi  = mem_rdata;
                    s_d.ptr = s_q.ptr + 1'b1;
                    s_d.st  = ST_LO;
                end
            end
            ST_LO: begin
                if (mem_ready) begin
                    s_d.ea   = {s_q.hi, mem_rdata};
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ptr: '0, hi: '0, ea: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign ea       = s_q.ea;
    assign mem_rd   = (s_q.st == ST_HI) || (s_q.st == ST_LO);
    assign mem_addr = s_q.ptr;

    // R8: a direct request completes in the next cycle
    p_direct_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_indirect) |=> (done && !busy));

    // R9: an indirect request opens a read and gives no result yet
    p_indirect_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_indirect) |=> (mem_rd && !done));

    // R9: the second byte comes from the next address
    p_low_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HI && mem_ready) |=> (mem_rd && mem_addr == $past(mem_addr) + 1'b1));

    // R10: a pending read holds its address
    p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R11: a result is only ever presented with the unit idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: reads only while a fetch is in progress
    p_rd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
endmodule

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;
    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_base = '0;
    logic [2:0]      req_ofs_kind = '0;
    logic            req_indirect = 1'b0;
    logic [AW-1:0]   req_const = '0;
    logic [AW-1:0]   reg_x = 16'h1000;
    logic [AW-1:0]   reg_y = 16'h2000;
    logic [AW-1:0]   reg_sp = 16'h3FF0;
    logic [AW-1:0]   reg_pc = 16'hFFF8;
    logic [7:0]      acc_a = 8'h80;
    logic [7:0]      acc_b = 8'h9C;
    logic            busy, done, mem_rd, mem_ready;
    logic [AW-1:0]   ea, mem_addr;
    logic [7:0]      mem_rdata;

    int checks = 0;
    int errors = 0;
    int wait_states = 0;
    int wcnt = 0;
    logic [AW-1:0] wait_addr = '0;
    logic [AW-1:0] exp_q [$];
    string         tag_q [$];

    always #2.5 clk = ~clk;

    idx_ea_gen #(.AW(AW)) u0 (
        .clk, .rst_n, .req_valid, .req_base, .req_ofs_kind, .req_indirect,
        .req_const, .reg_x, .reg_y, .reg_sp, .reg_pc, .acc_a, .acc_b,
        .busy, .done, .ea, .mem_rd, .mem_addr, .mem_ready, .mem_rdata
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic logic [15:0] calc_sum(input logic [1:0] bs, input logic [2:0] k,
                                             input logic [15:0] c);
        logic [15:0] b, o;
        case (bs)
            2'd0: b = reg_x;
            2'd1: b = reg_y;
            2'd2: b = reg_sp;
            default: b = reg_pc;
        endcase
        case (k)
            3'd0: o = 16'($signed(c[4:0]));
            3'd1: o = 16'($signed(c[8:0]));
            3'd2: o = c;
            3'd3: o = {8'h00, acc_a};
            3'd4: o = {8'h00, acc_b};
            3'd5: o = {acc_a, acc_b};
            default: o = 16'h0000;
        endcase
        return b + o;
    endfunction

    task automatic check(input string tag, input logic ok, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder with wait states
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            wcnt = 0;
        end else if (rst_n && mem_rd) begin
            if (wcnt == 0) wait_addr = mem_addr;
            if (wcnt >= wait_states) begin
                check("R10 address held", mem_addr == wait_addr, 32'(mem_addr), 32'(wait_addr));
                mem_rdata <= mem_byte(mem_addr);
                mem_ready <= 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    // monitor: pops the scoreboard on every result strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected done", 1'b0, 32'(ea), 32'h0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, ea == e, 32'(ea), 32'(e));
            end
        end
    end

    task automatic issue(input string tag, input logic [1:0] bs, input logic [2:0] k,
                         input logic ind, input logic [15:0] c);
        logic [15:0] s;
        while (busy) @(negedge clk);
        s = calc_sum(bs, k, c);
        req_base = bs; req_ofs_kind = k; req_indirect = ind; req_const = c;
        req_valid = 1'b1;
        exp_q.push_back(ind ? {mem_byte(s), mem_byte(s + 16'h1)} : s);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
        if (ind)
            check("R9 first read at sum", mem_rd && mem_addr == s, 32'(mem_addr), 32'(s));
        else
            check("R8 done next cycle", done == 1'b1, 32'(done), 32'h1);
    endtask

    task automatic poke_while_busy();
        while (!busy) @(negedge clk);
        req_base = 2'd1; req_ofs_kind = 3'd2; req_indirect = 1'b0; req_const = 16'h0123;
        req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        check("R11 still busy", busy == 1'b1, 32'(busy), 32'h1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        check("R1 reset busy/done/rd", !busy && !done && !mem_rd, {busy, done, mem_rd}, 32'h0);
        check("R1 reset ea", ea == 16'h0, 32'(ea), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        issue("R3 R2 c5 negative on X", 2'd0, 3'd0, 1'b0, 16'h001F);
        issue("R3 R2 c5 positive on Y", 2'd1, 3'd0, 1'b0, 16'hFF0F);
        issue("R4 R2 c9 -256 on SP", 2'd2, 3'd1, 1'b0, 16'h0100);
        issue("R4 R5 c9 +255 on PC wraps", 2'd3, 3'd1, 1'b0, 16'h00FF);
        issue("R5 full constant wraps", 2'd0, 3'd2, 1'b0, 16'hF000);
        issue("R6 acc A zero-extended", 2'd1, 3'd3, 1'b0, 16'h0000);
        issue("R6 acc B zero-extended", 2'd2, 3'd4, 1'b0, 16'h0000);
        issue("R6 double accumulator", 2'd0, 3'd5, 1'b0, 16'h0000);
        issue("R7 reserved kind 6", 2'd3, 3'd6, 1'b0, 16'h1234);
        issue("R7 reserved kind 7", 2'd0, 3'd7, 1'b0, 16'hFFFF);
        repeat (2) @(negedge clk);
        check("R8 ea held after done", ea == 16'h1000 && !done, 32'(ea), 32'h1000);

        wait_states = 0;
        issue("R9 indirect X+0x10 no wait", 2'd0, 3'd2, 1'b1, 16'h0010);
        wait_states = 2;
        issue("R9 indirect pointer at FFFF", 2'd3, 3'd2, 1'b1, 16'h0007);
        wait_states = 3;
        issue("R9 R11 indirect Y+D with poke", 2'd1, 3'd5, 1'b1, 16'h0000);
        poke_while_busy();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R11 no extra result", exp_q.size() == 0, 32'(exp_q.size()), 32'h0);
        check("R11 idle after fetch", !busy && !mem_rd, {busy, mem_rd}, 32'h0);
        finish_run();
    end
endmodule